// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single timer channel for a real-time-clock style peripheral. A host programs it through a small byte-wide register bus with separate write and read strobes. One of eight clock-enable inputs is selected as the count source. A prescaler divides that source by `PRE_DIV`, and each prescaler wrap decrements a 16-bit down counter. Each time the counter reaches zero, the channel raises a one-cycle timeout pulse.

There are four count modes: a one-shot that stops itself, a square wave with auto-reload, a rate generator with auto-reload, and a retriggerable one-shot. The retriggerable one-shot is fired by a rising edge on the gate input or by a control write. A latch-and-read mechanism freezes a copy of the running count so the host can read both bytes without tearing. The top control bit has two meanings. In the free-running modes it suspends counting and keeps the prescaler's partial progress. In the retriggerable mode it fires the count.

Top module: `ivt_chan`

## Requirements
- R1: After reset, the control register, the reload bytes and the holding bytes all read 0, and `tmo_pulse` and `wave_out` are low.
- R2: Register addresses are: 0 control, 1 reload low byte, 2 reload high byte, 3 holding low byte, 4 holding high byte. Control fields are: bit 0 start, bits 2:1 mode (0 one-shot, 1 square, 2 rate, 3 retrigger), bits 5:3 source select, bit 6 latch (RD), bit 7 CHG. The written fields read back, except that CHG always reads 0 in mode 3. `bus_rdata` is 0 when `bus_rd` is low.
- R3: A start write (bit 0 rising from 0 to 1) loads the reload value and clears the prescaler. With an always-active source, the first `tmo_pulse` follows the start write's clock edge by reload×`PRE_DIV` cycles. `tmo_pulse` is never high for two cycles in a row.
- R4: Bits 5:3 pick source input k. The counter decrements once per `PRE_DIV` active cycles of `src_en[k]`, so the steady rate-mode period is reload×`PRE_DIV`×(pulse spacing of source k).
- R5: Writing 0 to bit 0 clears the counter and the prescaler and stops counting. The next start counts the full reload×`PRE_DIV` again.
- R6: Mode 0 produces one timeout. On that timeout the hardware clears bit 0, the count stays 0, and `wave_out` is high from start until the timeout.
- R7: Mode 1 reloads at each timeout, and `wave_out` toggles at each timeout (it starts high).
- R8: Mode 2 reloads at each timeout. `wave_out` is low only in the cycle in which `tmo_pulse` is high, and high otherwise while counting.
- R9: Writing control with bit 6 = 1 copies the count into the holding register. While bit 6 is set the holding register does not change. While it is clear, the holding register follows the count.
- R10: A read of the holding low byte (address 3) clears bit 6, and so does a control write with bit 6 = 0.
- R11: In modes 0 to 2, a control write with bit 7 = 1 freezes both the counter and the prescaler without clearing them. A later write with bit 7 = 0 resumes, so the timeout is delayed by exactly the suspended cycles.
- R12: In mode 3, a start only arms the channel. A gate rising edge, or a control write with bit 7 = 1, loads the reload value and counts. Each further bit 7 write retriggers without a 0 in between, a held-high gate does not retrigger, and each trigger gives one timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| src_en | input | 8 | Candidate count-source enables |
| gate_in | input | 1 | Trigger input for mode 3 (rising edge) |
| tmo_pulse | output | 1 | One-cycle pulse each time the count reaches zero |
| wave_out | output | 1 | Mode-dependent output waveform |

## Verification
Rate mode is run with random reload values against each of eight sources of different pulse spacing. The steady interval between timeouts therefore separates a wrong source decode from a wrong prescale or reload length. Directed runs stop, suspend or latch part-way through a prescaler cycle, so exact timeout cycles show whether the prescaler was cleared or kept. Mode 3 is driven by a gate edge, a held-high gate and back-to-back CHG writes, which separates edge triggering from level triggering and shows that retriggering restarts the count.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 16;
    localparam int NUM_SRC = 8;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_RLD_LO = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_RLD_HI = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_HLD_LO = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_HLD_HI = ADDR_W'(4);

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_SQUARE  = 2'd1,
        MODE_RATE    = 2'd2,
        MODE_RETRIG  = 2'd3
    } ivt_mode_e;

    // Packed MSB first: chg(7) rd(6) src(5:3) mode(2:1) start(0)
    typedef struct packed {
        logic             chg;
        logic             rd;
        logic [SRC_W-1:0] src;
        ivt_mode_e        mode;
        logic             start;
    } ivt_ctrl_t;

    typedef struct packed {
        ivt_ctrl_t        ctrl;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             armed;
        logic             wave;
        logic             tmo;
    } ivt_state_t;

endpackage

// File: rtl/ivt_srcmux.sv
module ivt_srcmux #(
    parameter int N     = 8,
    parameter int SEL_W = 3
) (
    input  logic [N-1:0]     src,
    input  logic [SEL_W-1:0] sel,
    output logic             en
);

    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = src[i] && (sel == SEL_W'(i));
    end

    assign en = |hit;

endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic tick
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    if (DIV > 1) begin : g_div
        logic [PW-1:0] pre_d, pre_q;

        always_comb begin
            pre_d = pre_q;
            tick  = 1'b0;
            if (clr) begin
                pre_d = '0;
            end else if (adv) begin
                if (pre_q == LAST) begin
                    pre_d = '0;
                    tick  = 1'b1;
                end else begin
                    pre_d = pre_q + PW'(1);
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= pre_d;
        end
    end else begin : g_bypass
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign tick = adv && !clr;
    end

endmodule

// File: rtl/ivt_edge.sv
module ivt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl;
        rise  = lvl && !lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

endmodule

// File: rtl/ivt_chan.sv
module ivt_chan
    import ivt_pkg::*;
#(
    parameter int PRE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic              gate_in,
    output logic              tmo_pulse,
    output logic              wave_out
);

    ivt_state_t st_d, st_q;

    ivt_ctrl_t  wctrl;
    ivt_mode_e  eff_mode;
    logic       ctrl_wr, eff_start;
    logic       stop_req, start_req, trig_req, pre_clr;
    logic       running, sel_en, adv, tick, terminal, gate_rise;
    logic [BYTE_W-1:0] rd_mux;

    // ---- sub-blocks ----
    ivt_srcmux #(.N(NUM_SRC), .SEL_W(SRC_W)) u_mux (
        .src (src_en),
        .sel (st_q.ctrl.src),
        .en  (sel_en)
    );

    ivt_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .adv   (adv),
        .tick  (tick)
    );

    ivt_edge u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (gate_in),
        .rise  (gate_rise)
    );

    // ---- request decode (kept apart from the next-state block) ----
    always_comb begin : p_req
        wctrl     = ivt_ctrl_t'(bus_wdata);
        ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
        eff_start = ctrl_wr ? wctrl.start : st_q.ctrl.start;
        eff_mode  = ctrl_wr ? wctrl.mode  : st_q.ctrl.mode;
        stop_req  = ctrl_wr && !wctrl.start;
        start_req = ctrl_wr && wctrl.start && !st_q.ctrl.start;
        trig_req  = eff_start && (eff_mode == MODE_RETRIG)
                    && (gate_rise || (ctrl_wr && wctrl.chg));
        pre_clr   = stop_req || start_req || trig_req;
        running   = st_q.ctrl.start && !st_q.ctrl.chg
                    && ((st_q.ctrl.mode != MODE_RETRIG) || st_q.armed);
        adv       = running && sel_en;
    end

    // ---- next state ----
    always_comb begin : p_next
        st_d     = st_q;
        st_d.tmo = 1'b0;
        terminal = tick && (st_q.cnt == CNT_W'(1));

        // holding register follows the count unless a latch is pending
        if (!st_q.ctrl.rd) begin
            st_d.hold = st_q.cnt;
        end

        if ((st_q.ctrl.mode == MODE_RATE) && running) begin
            st_d.wave = 1'b1;
        end

        // counting
        if (tick) begin
            if (terminal) begin
                st_d.tmo = 1'b1;
                case (st_q.ctrl.mode)
                    MODE_ONESHOT: begin
                        st_d.cnt        = '0;
                        st_d.ctrl.start = 1'b0;
                        st_d.wave       = 1'b0;
                    end
                    MODE_SQUARE: begin
                        st_d.cnt  = st_q.reload;
                        st_d.wave = ~st_q.wave;
                    end
                    MODE_RATE: begin
                        st_d.cnt  = st_q.reload;
                        st_d.wave = 1'b0;
                    end
                    default: begin
                        st_d.cnt   = '0;
                        st_d.armed = 1'b0;
                        st_d.wave  = 1'b0;
                    end
                endcase
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        // reload bytes
        if (bus_wr && (bus_addr == A_RLD_LO)) begin
            st_d.reload[BYTE_W-1:0] = bus_wdata;
        end
        if (bus_wr && (bus_addr == A_RLD_HI)) begin
            st_d.reload[CNT_W-1:BYTE_W] = bus_wdata[CNT_W-BYTE_W-1:0];
        end

        // low-byte read ends a latched read
        if (bus_rd && (bus_addr == A_HLD_LO)) begin
            st_d.ctrl.rd = 1'b0;
        end

        // control write
        if (ctrl_wr) begin
            st_d.ctrl.mode = wctrl.mode;
            st_d.ctrl.src  = wctrl.src;
            st_d.ctrl.chg  = wctrl.chg && (wctrl.mode != MODE_RETRIG);
            st_d.ctrl.rd   = wctrl.rd;
            if (wctrl.rd) begin
                st_d.hold = st_q.cnt;
            end
            if (stop_req) begin
                st_d.ctrl.start = 1'b0;
                st_d.cnt        = '0;
                st_d.armed      = 1'b0;
                st_d.wave       = 1'b0;
            end else if (start_req) begin
                st_d.ctrl.start = 1'b1;
                st_d.cnt        = st_q.reload;
                st_d.armed      = 1'b0;
                st_d.wave       = (wctrl.mode != MODE_RETRIG);
            end
        end

        // mode 3 trigger / retrigger
        if (trig_req) begin
            st_d.cnt   = st_q.reload;
            st_d.armed = 1'b1;
            st_d.wave  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---- read port ----
    always_comb begin : p_read
        case (bus_addr)
            A_CTRL:   rd_mux = st_q.ctrl;
            A_RLD_LO: rd_mux = st_q.reload[BYTE_W-1:0];
            A_RLD_HI: rd_mux = st_q.reload[CNT_W-1:BYTE_W];
            A_HLD_LO: rd_mux = st_q.hold[BYTE_W-1:0];
            A_HLD_HI: rd_mux = st_q.hold[CNT_W-1:BYTE_W];
            default:  rd_mux = '0;
        endcase
        bus_rdata = bus_rd ? rd_mux : '0;
    end

    assign tmo_pulse = st_q.tmo;
    assign wave_out  = st_q.wave;

endmodule

// File: rtl/ivt_chan_chk.sv
module ivt_chan_chk
    import ivt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              tmo_pulse,
    input logic              start_q,
    input logic              rd_q,
    input logic              chg_q,
    input logic [1:0]        mode_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  hold_q
);

    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

    // R3: the timeout is a single-cycle pulse
    p_tmo_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> !tmo_pulse);

    // R5: a stop write leaves the counter cleared and idle
    p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[0]) |=> (cnt_q == '0) && !start_q);

    // R6: a one-shot timeout leaves the channel stopped at zero
    p_oneshot_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_pulse && (mode_q == 2'd0)) |-> (!start_q && (cnt_q == '0)));

    // R9: holding register frozen while a latch is pending
    p_hold_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && !ctrl_wr) |=> $stable(hold_q));

    // R10: reading the holding low byte ends the latch
    p_lo_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == A_HLD_LO) && !ctrl_wr) |=> !rd_q);

    // R11: a suspended channel does not count
    p_suspend_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && chg_q && !ctrl_wr) |=> $stable(cnt_q));

endmodule

bind ivt_chan ivt_chan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tmo_pulse (tmo_pulse),
    .start_q   (st_q.ctrl.start),
    .rd_q      (st_q.ctrl.rd),
    .chg_q     (st_q.ctrl.chg),
    .mode_q    (st_q.ctrl.mode),
    .cnt_q     (st_q.cnt),
    .hold_q    (st_q.hold)
);

// File: tb/sim_ivt_chan.sv
`timescale 1ns/1ps
module sim_ivt_chan;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] src_en = 8'hFF;
    logic       gate_in = 1'b0;
    logic       tmo_pulse, wave_out;

    int unsigned cyc = 0;
    int unsigned ncyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic tmo_wave;

    always #5 clk = ~clk;

    ivt_chan #(.PRE_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_en(src_en), .gate_in(gate_in), .tmo_pulse(tmo_pulse), .wave_out(wave_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // source k is active once every k+1 cycles
    always @(negedge clk) begin
        ncyc <= ncyc + 1;
        for (int k = 0; k < 8; k++) src_en[k] <= ((ncyc % (k + 1)) == 0);
    end

    function automatic int rate_period(input int rld, input int k);
        return rld * DIV * (k + 1);
    endfunction

    function automatic int latched_count(input int rld, input int t_start, input int t_latch);
        return rld - ((t_latch - 1 - t_start) / DIV);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_tmo(input int lim, output int c);
        c = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (tmo_pulse) begin
                c = int'(cyc);
                tmo_wave = wave_out;
                break;
            end
        end
    endtask

    task automatic count_tmo(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tmo_pulse) seen++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2;
        int t0, t1, ta, tb, c, c1, c2, c3, seen, exp_v, rld, k;
        bit w1, w2, w3;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // ---- R1 reset state ----
        rd(3'd0, d); check(d == 8'h00, "R1 ctrl", d, 0);
        rd(3'd1, d); check(d == 8'h00, "R1 reload lo", d, 0);
        rd(3'd3, d); check(d == 8'h00, "R1 hold lo", d, 0);
        check(!tmo_pulse && !wave_out, "R1 outputs", {tmo_pulse, wave_out}, 0);

        // ---- R2 register map readback ----
        wr(3'd0, 8'h2C); rd(3'd0, d); check(d == 8'h2C, "R2 ctrl readback", d, 8'h2C);
        wr(3'd1, 8'hA5); rd(3'd1, d); check(d == 8'hA5, "R2 reload lo", d, 8'hA5);
        wr(3'd2, 8'h3C); rd(3'd2, d); check(d == 8'h3C, "R2 reload hi", d, 8'h3C);
        @(negedge clk); #1 check(bus_rdata == 8'h00, "R2 rdata idle", bus_rdata, 0);
        wr(3'd0, 8'h00);

        // ---- R3/R6 one-shot ----
        wr(3'd2, 8'h00); wr(3'd1, 8'd5);
        wr(3'd0, 8'h01); t0 = int'(cyc);
        check(wave_out == 1'b1, "R6 wave high while running", wave_out, 1);
        wait_tmo(2000, c);
        check(c - t0 == 5 * DIV, "R3 first timeout delay", c - t0, 5 * DIV);
        @(negedge clk);
        check(!tmo_pulse, "R3 single-cycle pulse", tmo_pulse, 0);
        rd(3'd0, d); check(d[0] == 1'b0, "R6 start cleared", d[0], 0);
        count_tmo(100, seen); check(seen == 0, "R6 no second timeout", seen, 0);
        rd(3'd3, d); check(d == 8'h00, "R6 count stays zero", d, 0);
        check(wave_out == 1'b0, "R6 wave low after timeout", wave_out, 0);

        // ---- R5 stop mid-prescale clears, restart counts fully ----
        wr(3'd1, 8'd7);
        wr(3'd0, 8'h05);
        repeat (13) @(negedge clk);
        wr(3'd0, 8'h04);
        repeat (3) @(negedge clk);
        rd(3'd3, d); check(d == 8'h00, "R5 count cleared by stop", d, 0);
        count_tmo(60, seen); check(seen == 0, "R5 no timeout while stopped", seen, 0);
        wr(3'd0, 8'h05); t0 = int'(cyc);
        wait_tmo(2000, c);
        check(c - t0 == 7 * DIV, "R5 full count after restart", c - t0, 7 * DIV);
        wr(3'd0, 8'h00);

        // ---- R11 suspend keeps prescaler ----
        wr(3'd1, 8'd30);
        wr(3'd0, 8'h01); t0 = int'(cyc);
        repeat (13) @(negedge clk);
        wr(3'd0, 8'h81); ta = int'(cyc);
        rd(3'd0, d); check(d == 8'h81, "R11 suspend readback", d, 8'h81);
        rd(3'd3, d);
        repeat (10) @(negedge clk);
        rd(3'd3, d2); check(d == d2, "R11 count frozen", d2, d);
        wr(3'd0, 8'h01); tb = int'(cyc);
        wait_tmo(2000, c);
        check(c - t0 == 30 * DIV + (tb - ta), "R11 delay equals suspended cycles",
              c - t0, 30 * DIV + (tb - ta));
        wr(3'd0, 8'h00);

        // ---- R9/R10 latch and read ----
        wr(3'd1, 8'd200);
        wr(3'd0, 8'h05); t0 = int'(cyc);
        repeat (37) @(negedge clk);
        wr(3'd0, 8'h45); t1 = int'(cyc);
        exp_v = latched_count(200, t0, t1);
        repeat (50) @(negedge clk);
        rd(3'd0, d); check(d[6] == 1'b1, "R9 RD set", d[6], 1);
        rd(3'd4, d); check(d == 8'((exp_v >> 8) & 255), "R9 latched high byte", d, (exp_v >> 8) & 255);
        rd(3'd3, d); check(d == 8'(exp_v & 255), "R9 latched low byte", d, exp_v & 255);
        rd(3'd0, d); check(d == 8'h05, "R10 low read clears RD", d, 8'h05);
        wr(3'd0, 8'h45);
        rd(3'd4, d2);
        wr(3'd0, 8'h05);
        rd(3'd0, d); check(d[6] == 1'b0, "R10 abort clears RD", d[6], 0);
        repeat (20) @(negedge clk);
        rd(3'd3, d);
        check(int'(d) < exp_v - 8, "R9 holding follows count after abort", d, exp_v - 8);
        wr(3'd0, 8'h00);

        // ---- R8 rate wave ----
        wr(3'd1, 8'd3);
        wr(3'd0, 8'h05);
        wait_tmo(2000, c);
        check(tmo_wave == 1'b0, "R8 wave low at timeout", tmo_wave, 0);
        @(negedge clk);
        check(wave_out == 1'b1, "R8 wave high after timeout", wave_out, 1);
        wr(3'd0, 8'h00);

        // ---- R4/R8 random reload and source ----
        for (int it = 0; it < 8; it++) begin
            rld = 1 + int'($urandom % 12);
            k   = int'($urandom % 8);
            wr(3'd0, 8'h00);
            wr(3'd1, 8'(rld));
            wr(3'd0, 8'(8'h05 | (k << 3)));
            wait_tmo(5000, c1);
            wait_tmo(5000, c2);
            wait_tmo(5000, c3);
            check(c3 - c2 == rate_period(rld, k), "R4 rate period for source",
                  c3 - c2, rate_period(rld, k));
            check(c2 - c1 == rate_period(rld, k), "R8 auto-reload period",
                  c2 - c1, rate_period(rld, k));
        end
        wr(3'd0, 8'h00);

        // ---- R7 square wave ----
        wr(3'd1, 8'd3);
        wr(3'd0, 8'h13);
        wait_tmo(5000, c1); w1 = tmo_wave;
        wait_tmo(5000, c2); w2 = tmo_wave;
        wait_tmo(5000, c3); w3 = tmo_wave;
        check(c3 - c2 == rate_period(3, 2), "R7 square half period", c3 - c2, rate_period(3, 2));
        check((w1 != w2) && (w2 != w3), "R7 wave toggles", {w1, w2, w3}, 3'b010);
        wr(3'd0, 8'h00);

        // ---- R12 retriggerable one-shot ----
        wr(3'd1, 8'd10);
        wr(3'd0, 8'h07);
        count_tmo(100, seen); check(seen == 0, "R12 armed only", seen, 0);
        @(negedge clk); gate_in = 1'b1;
        @(negedge clk); t0 = int'(cyc);
        wait_tmo(2000, c);
        check(c - t0 == 10 * DIV, "R12 gate edge trigger", c - t0, 10 * DIV);
        count_tmo(100, seen); check(seen == 0, "R12 held gate no retrigger", seen, 0);
        wr(3'd0, 8'h87); ta = int'(cyc);
        rd(3'd0, d); check(d == 8'h07, "R2 CHG reads 0 in mode 3", d, 8'h07);
        repeat (12) @(negedge clk);
        wr(3'd0, 8'h87); tb = int'(cyc);
        wait_tmo(2000, c);
        check(c - tb == 10 * DIV, "R12 CHG retrigger restarts", c - tb, 10 * DIV);
        count_tmo(100, seen); check(seen == 0, "R12 one timeout per trigger", seen, 0);
        gate_in = 1'b0;
        wr(3'd0, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule